// File: doc/BRIEF.md
# Transfer Address Access Error Detector

This block sits beside the address generators of a DMA engine and decides, cycle by cycle, whether the current source-side or destination-side access has faulted. Each side presents a valid flag, its current address, a flag marking the first access of the transfer, a flag saying whether the address is being advanced this cycle, the advance direction and a bus error response. Both sides share one transfer-width code.

A side faults when its first address is not aligned to the transfer width, when advancing its address by the access size would carry past the top of the address space or borrow below zero, or when the bus answers its access with an error. Only the first fault of a transfer is reported. It appears as a one-cycle pulse together with a 3-bit error type and the 2-bit status code that the engine writes back into its descriptor. A new transfer re-arms the detector. If both sides fault in the same cycle, the source side wins.

Top module: `addr_fault_detect`

## Requirements
- R1: While reset is held and in the cycle after it is released, errValid, errType and descStatus are all zero.
- R2: On a side whose valid and first flags are both high, the width code 2'b01 (halfword) faults when address bit 0 is set. The codes 2'b10 (word) and 2'b11 (treated as word) fault when either of address bits 1:0 is set. The code 2'b00 (byte) never faults on alignment. With the first flag low, alignment is not checked.
- R3: With valid, step high and the direction flag low (increment), a side faults when address plus access size (1, 2 or 4 bytes for byte, halfword, word) carries out of 32 bits.
- R4: With valid, step high and the direction flag high (decrement), a side faults when address minus access size borrows, that is when the address is below the access size.
- R5: A bus error on a side whose valid flag is high is a fault.
- R6: A reported source-side fault carries errType 3'b001 and descStatus 2'b01.
- R7: A reported destination-side fault carries errType 3'b010 and descStatus 2'b10.
- R8: After one fault has been reported, further faults are ignored until xferStart is sampled high. A fault in the same cycle as xferStart belongs to the new transfer and is reported.
- R9: When source and destination fault in the same cycle, only the source fault is reported.
- R10: errValid rises exactly one clock after the cycle in which the fault is presented and lasts one cycle. While errValid is low, errType and descStatus are zero.
- R11: Fault conditions on a side whose valid flag is low are ignored, and faults are ignored from reset until the first xferStart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xferStart | input | 1 | Start of a new transfer; re-arms fault reporting |
| srcValid | input | 1 | Source access present this cycle |
| srcFirst | input | 1 | Source address is the transfer's start address |
| srcStep | input | 1 | Source address advances this cycle |
| srcDown | input | 1 | Source advance direction: 1 decrement, 0 increment |
| srcBusErr | input | 1 | Bus error response on the source access |
| srcAddr | input | 32 | Current source address |
| dstValid | input | 1 | Destination access present this cycle |
| dstFirst | input | 1 | Destination address is the transfer's start address |
| dstStep | input | 1 | Destination address advances this cycle |
| dstDown | input | 1 | Destination advance direction: 1 decrement, 0 increment |
| dstBusErr | input | 1 | Bus error response on the destination access |
| dstAddr | input | 32 | Current destination address |
| accWidth | input | 2 | Transfer width: 00 byte, 01 halfword, 10/11 word |
| errValid | output | 1 | One-cycle pulse reporting the transfer's first fault |
| errType | output | 3 | Error type: 001 source, 010 destination |
| descStatus | output | 2 | Descriptor status: 01 source, 10 destination |

## Verification
Directed cases place addresses exactly at the carry and borrow edges for each access size, one step inside them, and at every low-bit pattern under each width code. This separates a correct boundary from an off-by-one comparison and an alignment mask of the wrong width. Simultaneous source and destination faults, faults after a report, faults in the same cycle as a restart, and faults on sides that are not valid exercise the priority, first-fault latch and gating paths. A long random run biases addresses toward both ends of the address space and mixes all flags, so that wrong side codes or a mis-timed pulse stand out against an independent per-cycle model.

// File: rtl/afd_pkg.sv
package afd_pkg;
  localparam int NUM_LANES = 2;
  localparam int SRC_LANE  = 0;
  localparam int DST_LANE  = 1;
  localparam int TYPE_W    = 3;
  localparam int STAT_W    = 2;

  localparam logic [TYPE_W-1:0] ERR_SRC = 3'b001;
  localparam logic [TYPE_W-1:0] ERR_DST = 3'b010;
  localparam logic [STAT_W-1:0] ST_SRC  = 2'b01;
  localparam logic [STAT_W-1:0] ST_DST  = 2'b10;

  typedef enum logic [1:0] {
    WIDTH_BYTE = 2'b00,
    WIDTH_HALF = 2'b01,
    WIDTH_WORD = 2'b10,
    WIDTH_WIDE = 2'b11
  } accWidth_e;

  typedef struct packed {
    logic srcFault;
    logic dstFault;
  } faultStrobes_t;
endpackage

// File: rtl/afd_lane.sv
module afd_lane
  import afd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              valid,
  input  logic              first,
  input  logic              step,
  input  logic              down,
  input  logic              busErr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        width,
  output logic              fault
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] stepSize;
  logic [EXT_W-1:0] addrExt;
  logic [EXT_W-1:0] nextUp;
  logic [EXT_W-1:0] nextDown;
  logic             misaligned;
  logic             wrapUp;
  logic             wrapDown;
  logic             stepFault;

  always_comb begin
    unique case (accWidth_e'(width))
      WIDTH_BYTE: stepSize = EXT_W'(1);
      WIDTH_HALF: stepSize = EXT_W'(2);
      default:    stepSize = EXT_W'(4);
    endcase
  end

  always_comb begin
    unique case (accWidth_e'(width))
      WIDTH_BYTE: misaligned = 1'b0;
      WIDTH_HALF: misaligned = addr[0];
      default:    misaligned = |addr[1:0];
    endcase
  end

  assign addrExt   = {1'b0, addr};
  assign nextUp    = addrExt + stepSize;
  assign nextDown  = addrExt - stepSize;
  assign wrapUp    = nextUp[ADDR_W];
  assign wrapDown  = nextDown[ADDR_W];
  assign stepFault = step & (down ? wrapDown : wrapUp);
  assign fault     = valid & ((first & misaligned) | stepFault | busErr);

  assert_word_misalign_R2: assert property (@(posedge clk) disable iff (!rstN)
    (valid && first && width[1] && addr[1:0] != 2'b00) |-> fault);

  assert_byte_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !step && !busErr && width == 2'b00) |-> !fault);

  assert_wrap_up_R3: assert property (@(posedge clk) disable iff (!rstN)
    (valid && step && !down && (&addr)) |-> fault);

  assert_wrap_down_R4: assert property (@(posedge clk) disable iff (!rstN)
    (valid && step && down && addr == '0) |-> fault);

  assert_bus_error_R5: assert property (@(posedge clk) disable iff (!rstN)
    (valid && busErr) |-> fault);

  assert_idle_lane_R11: assert property (@(posedge clk) disable iff (!rstN)
    !valid |-> !fault);
endmodule

// File: rtl/afd_datapath.sv
module afd_datapath
  import afd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_LANES-1:0]             laneValid,
  input  logic [NUM_LANES-1:0]             laneFirst,
  input  logic [NUM_LANES-1:0]             laneStep,
  input  logic [NUM_LANES-1:0]             laneDown,
  input  logic [NUM_LANES-1:0]             laneBusErr,
  input  logic [NUM_LANES-1:0][ADDR_W-1:0] laneAddr,
  input  logic [1:0]                       accWidth,
  output faultStrobes_t                    strobes
);
  logic [NUM_LANES-1:0] laneFault;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    afd_lane #(.ADDR_W(ADDR_W)) u_lane (
      .clk    (clk),
      .rstN   (rstN),
      .valid  (laneValid[i]),
      .first  (laneFirst[i]),
      .step   (laneStep[i]),
      .down   (laneDown[i]),
      .busErr (laneBusErr[i]),
      .addr   (laneAddr[i]),
      .width  (accWidth),
      .fault  (laneFault[i])
    );
  end

  assign strobes.srcFault = laneFault[SRC_LANE];
  assign strobes.dstFault = laneFault[DST_LANE];
endmodule

// File: rtl/afd_control.sv
module afd_control
  import afd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              xferStart,
  input  faultStrobes_t     strobes,
  output logic              errValid,
  output logic [TYPE_W-1:0] errType,
  output logic [STAT_W-1:0] descStatus
);
  logic armed;
  logic armedEff;
  logic anyFault;
  logic report;

  assign armedEff = armed | xferStart;
  assign anyFault = strobes.srcFault | strobes.dstFault;
  assign report   = armedEff & anyFault;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed      <= 1'b0;
      errValid   <= 1'b0;
      errType    <= '0;
      descStatus <= '0;
    end else begin
      armed    <= armedEff & ~anyFault;
      errValid <= report;
      if (report) begin
        errType    <= strobes.srcFault ? ERR_SRC : ERR_DST;
        descStatus <= strobes.srcFault ? ST_SRC : ST_DST;
      end else begin
        errType    <= '0;
        descStatus <= '0;
      end
    end
  end

  assert_code_pair_R6: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> ((errType == ERR_SRC && descStatus == ST_SRC) ||
                  (errType == ERR_DST && descStatus == ST_DST)));

  assert_single_report_R8: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && !xferStart) |=> !errValid);

  assert_src_priority_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.srcFault && strobes.dstFault && (armed || xferStart))
      |-> (errValid && errType == ERR_SRC));

  assert_quiet_outputs_R10: assert property (@(posedge clk) disable iff (!rstN)
    !errValid |-> (errType == '0 && descStatus == '0));
endmodule

// File: rtl/addr_fault_detect.sv
module addr_fault_detect
  import afd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xferStart,
  input  logic              srcValid,
  input  logic              srcFirst,
  input  logic              srcStep,
  input  logic              srcDown,
  input  logic              srcBusErr,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic              dstValid,
  input  logic              dstFirst,
  input  logic              dstStep,
  input  logic              dstDown,
  input  logic              dstBusErr,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [1:0]        accWidth,
  output logic              errValid,
  output logic [2:0]        errType,
  output logic [1:0]        descStatus
);
  faultStrobes_t strobes;

  afd_datapath #(.ADDR_W(ADDR_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .laneValid  ({dstValid,  srcValid}),
    .laneFirst  ({dstFirst,  srcFirst}),
    .laneStep   ({dstStep,   srcStep}),
    .laneDown   ({dstDown,   srcDown}),
    .laneBusErr ({dstBusErr, srcBusErr}),
    .laneAddr   ({dstAddr,   srcAddr}),
    .accWidth   (accWidth),
    .strobes    (strobes)
  );

  afd_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .xferStart  (xferStart),
    .strobes    (strobes),
    .errValid   (errValid),
    .errType    (errType),
    .descStatus (descStatus)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(!rstN) |-> (!errValid && errType == 3'b000 && descStatus == 2'b00));
endmodule

// File: tb/tb_addr_fault_detect.sv
`timescale 1ns/1ps
module tb_addr_fault_detect;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xferStart = 1'b0;
  logic        srcValid = 1'b0, srcFirst = 1'b0, srcStep = 1'b0, srcDown = 1'b0, srcBusErr = 1'b0;
  logic [31:0] srcAddr = '0;
  logic        dstValid = 1'b0, dstFirst = 1'b0, dstStep = 1'b0, dstDown = 1'b0, dstBusErr = 1'b0;
  logic [31:0] dstAddr = '0;
  logic [1:0]  accWidth = 2'b00;
  logic        errValid;
  logic [2:0]  errType;
  logic [1:0]  descStatus;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  bit  armedModel = 1'b0;

  always #2.5 clk = ~clk;

  addr_fault_detect dut (
    .clk(clk), .rstN(rstN), .xferStart(xferStart),
    .srcValid(srcValid), .srcFirst(srcFirst), .srcStep(srcStep), .srcDown(srcDown),
    .srcBusErr(srcBusErr), .srcAddr(srcAddr),
    .dstValid(dstValid), .dstFirst(dstFirst), .dstStep(dstStep), .dstDown(dstDown),
    .dstBusErr(dstBusErr), .dstAddr(dstAddr),
    .accWidth(accWidth), .errValid(errValid), .errType(errType), .descStatus(descStatus)
  );

  function automatic bit sideFault(bit v, bit f, bit s, bit d, bit b, logic [31:0] a, logic [1:0] w);
    logic [32:0] sz;
    logic [32:0] ax;
    bit mis, ovf;
    sz  = (w == 2'b00) ? 33'd1 : (w == 2'b01) ? 33'd2 : 33'd4;
    mis = (w == 2'b00) ? 1'b0 : (w == 2'b01) ? a[0] : (a[1:0] != 2'b00);
    ax  = {1'b0, a};
    ovf = d ? (ax < sz) : (ax > (33'h0_FFFF_FFFF - sz));
    return v && ((f && mis) || (s && ovf) || b);
  endfunction

  task automatic clearIn();
    xferStart = 0;
    srcValid = 0; srcFirst = 0; srcStep = 0; srcDown = 0; srcBusErr = 0; srcAddr = '0;
    dstValid = 0; dstFirst = 0; dstStep = 0; dstDown = 0; dstBusErr = 0; dstAddr = '0;
    accWidth = 2'b00;
  endtask

  task automatic compare(string tag, bit expV, logic [2:0] expT, logic [1:0] expS);
    checks++;
    if (errValid !== expV || errType !== expT || descStatus !== expS) begin
      errors++;
      $display("FAIL %s: got valid=%0b type=%03b status=%02b, expected valid=%0b type=%03b status=%02b",
               tag, errValid, errType, descStatus, expV, expT, expS);
    end
  endtask

  // Inputs are already set (driven at a falling edge); predicts, clocks, compares.
  task automatic tick(string tag, bit useDirect, bit dV, logic [2:0] dT);
    bit sF, dF, armEff, expV;
    logic [2:0] expT;
    logic [1:0] expS;
    sF = sideFault(srcValid, srcFirst, srcStep, srcDown, srcBusErr, srcAddr, accWidth);
    dF = sideFault(dstValid, dstFirst, dstStep, dstDown, dstBusErr, dstAddr, accWidth);
    armEff = armedModel || xferStart;
    expV = armEff && (sF || dF);
    expT = !expV ? 3'b000 : (sF ? 3'b001 : 3'b010);
    armedModel = armEff && !(sF || dF);
    if (useDirect) begin
      expV = dV;
      expT = dT;
    end
    expS = (expT == 3'b001) ? 2'b01 : (expT == 3'b010) ? 2'b10 : 2'b00;
    @(negedge clk);
    compare(tag, expV, expT, expS);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    clearIn();
    repeat (3) @(negedge clk);
    compare("R1 reset held", 0, 3'b000, 2'b00);
    rstN = 1'b1;
    @(negedge clk);
    compare("R1 after release", 0, 3'b000, 2'b00);

    // R11: fault before any transfer start
    srcValid = 1; srcBusErr = 1;
    tick("R11 not armed", 1, 0, 3'b000);
    // R5 / R6: bus error on source
    xferStart = 1;
    tick("R5 R6 src bus error", 1, 1, 3'b001);
    clearIn();
    // R10: pulse drops next cycle, R8: second fault ignored
    dstValid = 1; dstBusErr = 1;
    tick("R8 R10 later fault ignored", 1, 0, 3'b000);
    // R2 / R7: destination word misaligned at start, with restart same cycle
    clearIn();
    xferStart = 1; dstValid = 1; dstFirst = 1; accWidth = 2'b10; dstAddr = 32'h0000_1002;
    tick("R2 R7 R8 dst word misaligned", 1, 1, 3'b010);
    // R2: halfword odd but not first -> no fault
    clearIn();
    xferStart = 1; srcValid = 1; accWidth = 2'b01; srcAddr = 32'h0000_1001;
    tick("R2 not first unchecked", 1, 0, 3'b000);
    // R2: byte odd first -> no fault
    clearIn();
    srcValid = 1; srcFirst = 1; accWidth = 2'b00; srcAddr = 32'h0000_0003;
    tick("R2 byte any alignment", 1, 0, 3'b000);
    // R2: halfword bit1 set but bit0 clear -> aligned
    srcAddr = 32'h0000_0002; accWidth = 2'b01;
    tick("R2 halfword aligned", 1, 0, 3'b000);
    // R2: code 11 treated as word
    accWidth = 2'b11; srcAddr = 32'h0000_0002;
    tick("R2 code 11 misaligned", 1, 1, 3'b001);
    // R3: increment boundaries
    clearIn();
    xferStart = 1; srcValid = 1; srcStep = 1; accWidth = 2'b01; srcAddr = 32'hFFFF_FFFD;
    tick("R3 halfword top no carry", 1, 0, 3'b000);
    clearIn();
    srcValid = 1; srcStep = 1; accWidth = 2'b01; srcAddr = 32'hFFFF_FFFE;
    tick("R3 halfword carry", 1, 1, 3'b001);
    clearIn();
    xferStart = 1; dstValid = 1; dstStep = 1; accWidth = 2'b10; dstAddr = 32'hFFFF_FFFB;
    tick("R3 word no carry", 1, 0, 3'b000);
    clearIn();
    dstValid = 1; dstStep = 1; accWidth = 2'b10; dstAddr = 32'hFFFF_FFFC;
    tick("R3 R7 word carry", 1, 1, 3'b010);
    // R4: decrement boundaries
    clearIn();
    xferStart = 1; dstValid = 1; dstStep = 1; dstDown = 1; accWidth = 2'b10; dstAddr = 32'h0000_0004;
    tick("R4 word no borrow", 1, 0, 3'b000);
    clearIn();
    dstValid = 1; dstStep = 1; dstDown = 1; accWidth = 2'b10; dstAddr = 32'h0000_0003;
    tick("R4 word borrow", 1, 1, 3'b010);
    clearIn();
    xferStart = 1; srcValid = 1; srcStep = 1; srcDown = 1; accWidth = 2'b00; srcAddr = 32'h0000_0000;
    tick("R4 byte borrow", 1, 1, 3'b001);
    // R11: not-valid side ignored
    clearIn();
    xferStart = 1; dstBusErr = 1; dstStep = 1; dstAddr = 32'hFFFF_FFFF; srcBusErr = 1;
    tick("R11 invalid sides", 1, 0, 3'b000);
    // R9: both sides at once
    clearIn();
    srcValid = 1; srcBusErr = 1; dstValid = 1; dstBusErr = 1;
    tick("R9 source wins", 1, 1, 3'b001);
    clearIn();
    tick("R10 pulse one cycle", 1, 0, 3'b000);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      clearIn();
      xferStart = ($urandom % 8) == 0;
      accWidth  = 2'($urandom);
      srcValid = ($urandom % 2) == 0; srcFirst = ($urandom % 4) == 0;
      srcStep = ($urandom % 2) == 0;  srcDown = ($urandom % 2) == 0;
      srcBusErr = ($urandom % 16) == 0;
      dstValid = ($urandom % 2) == 0; dstFirst = ($urandom % 4) == 0;
      dstStep = ($urandom % 2) == 0;  dstDown = ($urandom % 2) == 0;
      dstBusErr = ($urandom % 16) == 0;
      case ($urandom % 3)
        0: srcAddr = 32'hFFFF_FFF8 | 32'($urandom % 8);
        1: srcAddr = 32'($urandom % 8);
        default: srcAddr = $urandom;
      endcase
      case ($urandom % 3)
        0: dstAddr = 32'hFFFF_FFF8 | 32'($urandom % 8);
        1: dstAddr = 32'($urandom % 8);
        default: dstAddr = $urandom;
      endcase
      tick("R8 R9 R10 random", 0, 0, 3'b000);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule